// File: doc/BRIEF.md
# Data Bus Tenure Controller

This block sits on the master side of a split-transaction, pipelined processor bus. Address tenures complete ahead of their data. Each completed address tenure is pushed into a small ordered queue as a read or write, a burst or single beat, and a tag. The block watches the data bus grant, the shared busy line, the data retry line and a tagged address retry. It decides when it may become data bus master and which queued tenure to move.

Once it owns the data bus, it drives the busy line and counts transfer acknowledges until the tenure is complete. It then retires the entry and reports its tag. A write-only grant lets the oldest queued write go ahead of earlier pipelined reads. A data retry during a read throws the tenure back for a new grant. In the busy-output-only configuration the shared busy line is not sampled. This suits systems where each master has its own busy wire.

Top module: `dtenure_ctrl`

## Requirements
- R1: A grant is qualified, and a tenure starts, when `dgrant`=1, `data_retry`=0, the queue is non-empty and the block is not master, and neither of the blocking conditions in R2 and R3 applies. On the next clock edge `dbusy_out`=1, `dbusy_oe`=1 and `start_valid` pulses for one cycle with the tag and direction of the chosen entry. If `data_retry`=1, no tenure starts.
- R2: An `addr_retry`=1 blocks qualification only when `addr_retry_tag` equals the tag of the candidate entry. A retry carrying any other tag has no effect.
- R3: With `cfg_busy_out_only`=0, `dbusy_in`=1 blocks qualification. With `cfg_busy_out_only`=1, `dbusy_in` is ignored.
- R4: When `wr_only_grant`=0, the entry started is always the oldest queued entry (queue head).
- R5: When `wr_only_grant`=1 with a qualified grant, the oldest queued write starts even if reads are queued ahead of it. If no write is queued, the oldest read starts.
- R6: A burst tenure (`enq_burst`=1) completes on its fourth asserted `xfer_ack` and a single tenure (`enq_burst`=0) completes on its first. In the cycle after the final acknowledge, `dbusy_out` is 0 and `done_valid` pulses with the tenure's tag.
- R7: `data_retry`=1 during a read tenure ends the tenure in the next cycle without `done_valid`. The entry stays at the queue head and restarts from beat one on a later grant. `data_retry` has no effect during a write tenure.
- R8: The queue holds 4 entries and `q_full`=1 while 4 are held. An enqueue while full is ignored.
- R9: Out of reset, and whenever the block is not master, `dbusy_out`=0 and `dbusy_oe`=0.
- R10: An enqueue in the same cycle as the final acknowledge of another tenure is accepted (the queue is not full), and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_busy_out_only | input | 1 | 1: do not sample the shared busy line |
| enq_valid | input | 1 | Completed address tenure to queue |
| enq_write | input | 1 | Queued tenure is a write |
| enq_burst | input | 1 | Queued tenure is a four-beat burst |
| enq_tag | input | 4 | Tag of the queued tenure |
| q_full | output | 1 | Queue full, back-pressure to address side |
| dgrant | input | 1 | Data bus grant |
| dbusy_in | input | 1 | Shared data bus busy as observed |
| data_retry | input | 1 | Data retry from the bus |
| addr_retry | input | 1 | Address retry |
| addr_retry_tag | input | 4 | Tag of the address tenure being retried |
| wr_only_grant | input | 1 | Grant restricted to a queued write when one exists |
| xfer_ack | input | 1 | Transfer acknowledge, one per beat |
| dbusy_out | output | 1 | Data bus busy driven by this master |
| dbusy_oe | output | 1 | Output enable of the busy driver |
| start_valid | output | 1 | One-cycle pulse: a tenure began |
| start_write | output | 1 | Direction of the started tenure |
| start_tag | output | 4 | Tag of the started tenure |
| done_valid | output | 1 | One-cycle pulse: a tenure retired |
| done_tag | output | 4 | Tag of the retired tenure |

## Verification
A new address tenure can be pushed into the queue in the same cycle that the final acknowledge retires another entry. That retirement can also sit in the middle of the queue after a write-only bypass. The bench provokes this by raising `enq_valid` together with the last `xfer_ack`. The scoreboard then expects the new tag to start on the next grant, with no lost or doubled entry. It also drives a data retry in the middle of a read burst. It expects that tag to start twice but to be reported done only once.

// File: rtl/dt_pkg.sv
// Package: shared entry type and widths for the data tenure controller.
// Assumes tags are small; all modules import this package.
package dt_pkg;
    parameter int DT_TAG_W = 4;

    typedef struct packed {
        logic                is_wr;
        logic                burst;
        logic [DT_TAG_W-1:0] tag;
    } dt_ent_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } dt_state_e;
endpackage

// File: rtl/dt_queue.sv
// Module: ordered pending-tenure queue with removal at any index.
// Entries are appended at the tail and removed at pop_idx, with the younger
// entries shifting down, so index 0 is always the oldest. The candidate is
// the head, or the oldest write when wr_only is set and a write exists.
// Assumes pop_idx names a held entry whenever pop is high.
module dt_queue
    import dt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  dt_ent_t                      push_ent,
    input  logic                         pop,
    input  logic [$clog2(DEPTH)-1:0]     pop_idx,
    input  logic                         wr_only,
    output logic                         full,
    output logic                         cand_valid,
    output logic [$clog2(DEPTH)-1:0]     cand_idx,
    output dt_ent_t                      cand_ent
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    dt_ent_t           mem [DEPTH];
    dt_ent_t           nxt [DEPTH];
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  ncnt;
    logic              w_found;
    logic [IDX_W-1:0]  w_idx;

    assign full = (count == CNT_W'(DEPTH));

    // Purpose: find the oldest queued write.
    always_comb begin
        w_found = 1'b0;
        w_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i < int'(count) && mem[i].is_wr) begin
                w_found = 1'b1;
                w_idx   = IDX_W'(i);
            end
        end
    end

    // Purpose: pick the entry the next data tenure would carry.
    always_comb begin
        cand_valid = (count != '0);
        cand_idx   = (wr_only && w_found) ? w_idx : '0;
        cand_ent   = mem[cand_idx];
    end

    // Purpose: compute the queue after this cycle's removal and append.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = mem[i];
        ncnt = count;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(pop_idx)) nxt[i] = mem[i + 1];
            end
            ncnt = ncnt - 1'b1;
        end
        if (push && !full) begin
            nxt[ncnt[IDX_W-1:0]] = push_ent;
            ncnt = ncnt + 1'b1;
        end
    end

    // Purpose: register queue contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            count <= ncnt;
            for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH))
        else $error("queue occupancy above depth");

    p_pop_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (CNT_W'(pop_idx) < count))
        else $error("retire of an empty slot");

    p_full_blocks_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full)
        else $error("full queue changed on push");
endmodule

// File: rtl/dt_qualify.sv
// Module: data bus grant qualification.
// A grant qualifies when the block is idle with work queued and no blocker
// is present. An address retry blocks only if its tag matches the candidate.
// In busy-output-only mode the observed busy line is disregarded.
module dt_qualify
    import dt_pkg::*;
(
    input  logic                 cfg_busy_out_only,
    input  logic                 dgrant,
    input  logic                 dbusy_in,
    input  logic                 data_retry,
    input  logic                 addr_retry,
    input  logic [DT_TAG_W-1:0]  addr_retry_tag,
    input  logic                 master,
    input  logic                 cand_valid,
    input  logic [DT_TAG_W-1:0]  cand_tag,
    output logic                 qual
);
    logic busy_seen;
    logic ar_hit;

    // Purpose: evaluate each blocker and combine into the qualified grant.
    always_comb begin
        busy_seen = dbusy_in && !cfg_busy_out_only;
        ar_hit    = addr_retry && (addr_retry_tag == cand_tag);
        qual      = dgrant && cand_valid && !master
                    && !busy_seen && !data_retry && !ar_hit;
    end
endmodule

// File: rtl/dt_tenure_fsm.sv
// Module: data tenure sequencer.
// Starts a tenure on a qualified grant, counts acknowledged beats, retires
// the entry after the last beat and aborts a read on data retry.
// Assumes the queue keeps the active entry at act_idx until it is retired.
module dt_tenure_fsm
    import dt_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int BURST_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         qual,
    input  logic [$clog2(DEPTH)-1:0]     cand_idx,
    input  dt_ent_t                      cand_ent,
    input  logic                         xfer_ack,
    input  logic                         data_retry,
    output logic                         master,
    output logic                         start_valid,
    output logic                         start_write,
    output logic [DT_TAG_W-1:0]          start_tag,
    output logic                         done_valid,
    output logic [DT_TAG_W-1:0]          done_tag,
    output logic                         pop,
    output logic [$clog2(DEPTH)-1:0]     pop_idx
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int BEAT_W = $clog2(BURST_LEN + 1);

    dt_state_e          state;
    dt_ent_t            act_ent;
    logic [IDX_W-1:0]   act_idx;
    logic [BEAT_W-1:0]  beats_left;
    logic               abort;
    logic               last;

    assign master  = (state == ST_XFER);
    assign abort   = master && data_retry && !act_ent.is_wr;
    assign last    = (beats_left == BEAT_W'(1));
    assign pop     = master && xfer_ack && last && !abort;
    assign pop_idx = act_idx;

    // Purpose: tenure state, beat count and start/done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            act_ent     <= '0;
            act_idx     <= '0;
            beats_left  <= '0;
            start_valid <= 1'b0;
            start_write <= 1'b0;
            start_tag   <= '0;
            done_valid  <= 1'b0;
            done_tag    <= '0;
        end else begin
            start_valid <= 1'b0;
            done_valid  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (qual) begin
                        state       <= ST_XFER;
                        act_ent     <= cand_ent;
                        act_idx     <= cand_idx;
                        beats_left  <= cand_ent.burst ? BEAT_W'(BURST_LEN) : BEAT_W'(1);
                        start_valid <= 1'b1;
                        start_write <= cand_ent.is_wr;
                        start_tag   <= cand_ent.tag;
                    end
                end
                ST_XFER: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (xfer_ack) begin
                        if (last) begin
                            state      <= ST_IDLE;
                            done_valid <= 1'b1;
                            done_tag   <= act_ent.tag;
                        end else begin
                            beats_left <= beats_left - 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_start_needs_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> $past(qual))
        else $error("tenure started without a qualified grant");

    p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(xfer_ack) && !master))
        else $error("retire without acknowledge");

    p_abort_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!master && !done_valid))
        else $error("read retry did not release the bus");
endmodule

// File: rtl/dtenure_ctrl.sv
// Module: processor data bus tenure controller (top).
// Joins the pending queue, grant qualification and tenure sequencer, and
// drives the busy line with a separate output enable.
// Assumes the address side honours q_full.
module dtenure_ctrl
    import dt_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_busy_out_only,
    input  logic                 enq_valid,
    input  logic                 enq_write,
    input  logic                 enq_burst,
    input  logic [DT_TAG_W-1:0]  enq_tag,
    output logic                 q_full,
    input  logic                 dgrant,
    input  logic                 dbusy_in,
    input  logic                 data_retry,
    input  logic                 addr_retry,
    input  logic [DT_TAG_W-1:0]  addr_retry_tag,
    input  logic                 wr_only_grant,
    input  logic                 xfer_ack,
    output logic                 dbusy_out,
    output logic                 dbusy_oe,
    output logic                 start_valid,
    output logic                 start_write,
    output logic [DT_TAG_W-1:0]  start_tag,
    output logic                 done_valid,
    output logic [DT_TAG_W-1:0]  done_tag
);
    localparam int IDX_W = $clog2(DEPTH);

    dt_ent_t            push_ent;
    dt_ent_t            cand_ent;
    logic               cand_valid;
    logic [IDX_W-1:0]   cand_idx;
    logic               pop;
    logic [IDX_W-1:0]   pop_idx;
    logic               qual;
    logic               master;

    assign push_ent = '{is_wr: enq_write, burst: enq_burst, tag: enq_tag};

    dt_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (enq_valid),
        .push_ent   (push_ent),
        .pop        (pop),
        .pop_idx    (pop_idx),
        .wr_only    (wr_only_grant),
        .full       (q_full),
        .cand_valid (cand_valid),
        .cand_idx   (cand_idx),
        .cand_ent   (cand_ent)
    );

    dt_qualify u_qual (
        .cfg_busy_out_only (cfg_busy_out_only),
        .dgrant            (dgrant),
        .dbusy_in          (dbusy_in),
        .data_retry        (data_retry),
        .addr_retry        (addr_retry),
        .addr_retry_tag    (addr_retry_tag),
        .master            (master),
        .cand_valid        (cand_valid),
        .cand_tag          (cand_ent.tag),
        .qual              (qual)
    );

    dt_tenure_fsm #(.DEPTH(DEPTH), .BURST_LEN(BURST_LEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual        (qual),
        .cand_idx    (cand_idx),
        .cand_ent    (cand_ent),
        .xfer_ack    (xfer_ack),
        .data_retry  (data_retry),
        .master      (master),
        .start_valid (start_valid),
        .start_write (start_write),
        .start_tag   (start_tag),
        .done_valid  (done_valid),
        .done_tag    (done_tag),
        .pop         (pop),
        .pop_idx     (pop_idx)
    );

    // Purpose: drive busy only while master; release the driver otherwise.
    always_comb begin
        dbusy_out = master;
        dbusy_oe  = master;
    end

    p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_busy_out_only && dbusy_in && !dbusy_out) |=> !start_valid)
        else $error("started while bus busy observed");

    p_retry_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_retry && !dbusy_out) |=> !dbusy_out)
        else $error("started during data retry");

    p_start_takes_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> (dbusy_out && dbusy_oe))
        else $error("start without bus ownership");
endmodule

// File: tb/test_dtenure_ctrl.sv
`timescale 1ns/1ps
module test_dtenure_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_busy_out_only = 1'b0;
    logic enq_valid = 1'b0, enq_write = 1'b0, enq_burst = 1'b0;
    logic [3:0] enq_tag = '0;
    logic q_full;
    logic dgrant = 1'b0, dbusy_in = 1'b0, data_retry = 1'b0, addr_retry = 1'b0;
    logic [3:0] addr_retry_tag = '0;
    logic wr_only_grant = 1'b0, xfer_ack = 1'b0;
    logic dbusy_out, dbusy_oe, start_valid, start_write, done_valid;
    logic [3:0] start_tag, done_tag;

    int n_chk = 0;
    int n_fail = 0;
    int exp_s_tag[$];
    int exp_s_wr[$];
    int exp_d_tag[$];

    always #2.5 clk = ~clk;

    dtenure_ctrl i_dtenure_ctrl (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic enq(int wr, int bu, int tag);
        enq_valid = 1'b1; enq_write = wr[0]; enq_burst = bu[0]; enq_tag = tag[3:0];
        tick();
        enq_valid = 1'b0;
    endtask

    task automatic exp_start(int tag, int wr);
        exp_s_tag.push_back(tag);
        exp_s_wr.push_back(wr);
    endtask

    task automatic grant(int wo);
        dgrant = 1'b1; wr_only_grant = wo[0];
        tick();
        dgrant = 1'b0; wr_only_grant = 1'b0;
    endtask

    task automatic beats(int n);
        for (int i = 0; i < n; i++) begin
            xfer_ack = 1'b1;
            tick();
        end
        xfer_ack = 1'b0;
    endtask

    // Scoreboard monitor: pops expected items as the design reports them.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 oe tracks busy", int'(dbusy_oe), int'(dbusy_out));
            if (start_valid) begin
                if (exp_s_tag.size() == 0) begin
                    chk("R4/R5 unexpected start tag", int'(start_tag), -1);
                end else begin
                    chk("R4/R5 start tag", int'(start_tag), exp_s_tag.pop_front());
                    chk("R1 start direction", int'(start_write), exp_s_wr.pop_front());
                end
            end
            if (done_valid) begin
                if (exp_d_tag.size() == 0) begin
                    chk("R6/R7 unexpected done tag", int'(done_tag), -1);
                end else begin
                    chk("R6 done tag", int'(done_tag), exp_d_tag.pop_front());
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state
        chk("R9 reset busy", int'(dbusy_out), 0);
        chk("R9 reset oe", int'(dbusy_oe), 0);
        chk("R8 reset full", int'(q_full), 0);

        // R3 observed busy blocks; R1 data retry blocks
        enq(0, 0, 1);
        dbusy_in = 1'b1; grant(0); dbusy_in = 1'b0;
        chk("R3 busy blocks grant", int'(dbusy_out), 0);
        data_retry = 1'b1; grant(0); data_retry = 1'b0;
        chk("R1 retry blocks grant", int'(dbusy_out), 0);
        // R2 retry for another tag is ignored
        addr_retry = 1'b1; addr_retry_tag = 4'd9;
        exp_start(1, 0); exp_d_tag.push_back(1);
        grant(0);
        addr_retry = 1'b0;
        chk("R2 foreign retry ignored", int'(dbusy_out), 1);
        beats(1);
        chk("R6 single released", int'(dbusy_out), 0);

        // R2 matching retry blocks
        enq(0, 0, 2);
        addr_retry = 1'b1; addr_retry_tag = 4'd2; grant(0); addr_retry = 1'b0;
        chk("R2 matching retry blocks", int'(dbusy_out), 0);
        exp_start(2, 0); exp_d_tag.push_back(2);
        grant(0); beats(1);

        // R6 burst of four beats
        enq(1, 1, 3);
        exp_start(3, 1); exp_d_tag.push_back(3);
        grant(0); beats(3);
        chk("R6 burst still held", int'(dbusy_out), 1);
        tick();
        chk("R6 idle ack cycle holds", int'(dbusy_out), 1);
        beats(1);
        chk("R6 burst released", int'(dbusy_out), 0);

        // R3 busy-output-only mode ignores observed busy
        cfg_busy_out_only = 1'b1;
        enq(0, 0, 4);
        exp_start(4, 0); exp_d_tag.push_back(4);
        dbusy_in = 1'b1; grant(0); dbusy_in = 1'b0;
        chk("R3 busy ignored in mode", int'(dbusy_out), 1);
        beats(1);
        cfg_busy_out_only = 1'b0;

        // R5 write-only bypass and R4 in-order
        enq(0, 0, 6); enq(0, 0, 7); enq(1, 0, 8); enq(1, 0, 9);
        chk("R8 full at four", int'(q_full), 1);
        exp_start(8, 1); exp_d_tag.push_back(8);
        grant(1); beats(1);
        exp_start(6, 0); exp_d_tag.push_back(6);
        grant(0); beats(1);
        exp_start(7, 0); exp_d_tag.push_back(7);
        grant(0); beats(1);
        exp_start(9, 1); exp_d_tag.push_back(9);
        grant(1); beats(1);
        enq(0, 0, 10);
        exp_start(10, 0); exp_d_tag.push_back(10);
        grant(1); beats(1);

        // R7 data retry mid read burst, then ignored in a write
        enq(0, 1, 11); enq(0, 0, 12);
        exp_start(11, 0);
        grant(0); beats(1);
        data_retry = 1'b1; tick(); data_retry = 1'b0;
        chk("R7 read retry releases", int'(dbusy_out), 0);
        exp_start(11, 0); exp_d_tag.push_back(11);
        grant(0); beats(3);
        chk("R7 restart counts from one", int'(dbusy_out), 1);
        beats(1);
        exp_start(12, 0); exp_d_tag.push_back(12);
        grant(0); beats(1);
        enq(1, 0, 13);
        exp_start(13, 1); exp_d_tag.push_back(13);
        grant(0);
        data_retry = 1'b1; beats(1); data_retry = 1'b0;
        chk("R7 write ignores retry", int'(dbusy_out), 0);

        // R8 enqueue while full is ignored
        enq(0, 0, 1); enq(0, 0, 2); enq(0, 0, 3); enq(0, 0, 4);
        chk("R8 full flag", int'(q_full), 1);
        enq(0, 0, 15);
        chk("R8 full stays", int'(q_full), 1);
        for (int t = 1; t <= 4; t++) begin
            exp_start(t, 0); exp_d_tag.push_back(t);
            grant(0); beats(1);
        end
        chk("R8 drained not full", int'(q_full), 0);
        grant(0);
        chk("R8 dropped entry absent", int'(dbusy_out), 0);

        // R10 enqueue together with final acknowledge
        enq(0, 0, 5);
        exp_start(5, 0); exp_d_tag.push_back(5);
        grant(0);
        enq_valid = 1'b1; enq_write = 1'b1; enq_burst = 1'b0; enq_tag = 4'd6;
        beats(1);
        enq_valid = 1'b0;
        exp_start(6, 1); exp_d_tag.push_back(6);
        grant(0);
        chk("R10 new entry started", int'(dbusy_out), 1);
        beats(1);
        tick();

        chk("R4 all starts seen", exp_s_tag.size(), 0);
        chk("R6 all dones seen", exp_d_tag.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule